// File: doc/BRIEF.md
# Delayed-Write Cache Data RAM Bypass

This block fronts a synchronous cache data RAM whose writes are issued one cycle after they are presented. A store hit or a refill beat arrives on the write port in the same cycle as its tag match. It is held in a pipeline register, and it reaches the RAM on the following clock edge. That extra cycle takes the tag compare out of the path to the RAM write enable. Without further help, a load that follows closely would read stale bytes.

To hide the late write, the block keeps the last two presented writes in two bypass stages. A load request gets its data one cycle after it is presented. In that cycle each byte lane is taken from the newer stage, the older stage or the RAM output. The choice depends on which stage matches the load's index and way and has that lane enabled. A load presented in the same cycle as a store to the same word, or in the cycle after it, therefore returns the stored bytes. Later loads read them from the RAM. Refill writes use the same path, so a refilled word becomes visible to loads as soon as it is presented.

Top module: `delayed_write_bypass`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `rd_vld_o` is low. A read presented in cycle R raises `rd_vld_o` in cycle R+1 and at no other time.
- R2: When no write to the same index and way is presented in cycle R or R-1, a read presented in cycle R returns in R+1 the data the RAM holds. This includes every write presented in cycle R-2 or earlier.
- R3: A full write (all byte enables set) presented in the same cycle R as a read of the same index and way is returned in full by that read in cycle R+1.
- R4: A full write to the same index and way presented in cycle R-1 is returned in full by a read presented in cycle R. This holds when no write is presented in cycle R.
- R5: Byte enable bit k covers data bits 8k+7 down to 8k. Lanes a bypassed write does not enable come from the next older source: the older stage, then the RAM.
- R6: When the writes of cycles R and R-1 both match the read and both enable a lane, the read returns the lane from the cycle R write.
- R7: A write forwards only when both its index and its way equal those of the read. A write to another way of the same index, or to another index in the same way, leaves the read's data unchanged.
- R8: A write presented in cycle R+1 or later has no effect on the data returned for a read presented in cycle R.
- R9: A write presented with `wr_valid_i` low changes neither the forwarded data nor the RAM contents.
- R10: Writes presented in every cycle, as in a refill burst, mixed with reads in every cycle, always return the most recently presented bytes for each index and way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid_i | input | 1 | Write (store hit or refill beat) present |
| wr_index_i | input | IDX_W (6) | Set index of the write |
| wr_way_i | input | WAY_W (1) | Way of the write |
| wr_be_i | input | LANES (8) | Byte enables, bit k = byte lane k |
| wr_data_i | input | DATA_W (64) | Write data |
| rd_valid_i | input | 1 | Load read request present |
| rd_index_i | input | IDX_W (6) | Set index of the read |
| rd_way_i | input | WAY_W (1) | Way of the read |
| rd_vld_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | DATA_W (64) | Read data with bypassed bytes merged in |

## Verification
The hardest case to reach is a read in which both bypass stages and the RAM each supply different lanes of the same word. This needs two partial writes to one index and way in consecutive cycles, with the read arriving alongside the second write, and it is rare under plain random traffic. Directed tasks build this case explicitly, along with its same-cycle and next-cycle variants. A random phase then hammers four entries with random byte enables, so that back-to-back collisions appear in most cycles and every result is compared with a byte-wise reference array.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

    parameter int unsigned SETS   = 64;
    parameter int unsigned WAYS   = 2;
    parameter int unsigned DATA_W = 64;

    localparam int unsigned IDX_W   = $clog2(SETS);
    localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned ADDR_W  = IDX_W + WAY_W;
    localparam int unsigned ENTRIES = SETS << WAY_W;

    // One write as held in a bypass stage
    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [WAY_W-1:0]  way;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // One pending read lookup
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
    } rd_req_t;

    // Source chosen for one byte lane of the read result
    typedef enum logic [1:0] {
        SRC_RAM = 2'd0,
        SRC_OLD = 2'd1,
        SRC_NEW = 2'd2
    } lane_src_e;

    function automatic logic [ADDR_W-1:0] flat_addr(
        input logic [IDX_W-1:0] idx,
        input logic [WAY_W-1:0] way
    );
        return {idx, way};
    endfunction

    function automatic logic stage_hits(input wr_req_t w, input rd_req_t r);
        return w.vld && r.vld && (w.idx == r.idx) && (w.way == r.way);
    endfunction

endpackage

// File: rtl/dwb_wr_pipe.sv
module dwb_wr_pipe
    import dwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req_i,
    output wr_req_t stg_new_o,
    output wr_req_t stg_old_o
);

    wr_req_t stg_new_q;
    wr_req_t stg_old_q;

    // The newer stage also drives the RAM write; the older stage only
    // covers the cycle in which the RAM read still misses that write.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_new_q <= '0;
            stg_old_q <= '0;
        end else begin
            stg_new_q <= req_i;
            stg_old_q <= stg_new_q;
        end
    end

    assign stg_new_o = stg_new_q;
    assign stg_old_o = stg_old_q;

endmodule

// File: rtl/dwb_data_ram.sv
module dwb_data_ram
    import dwb_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [ENTRIES];

    // Read-first: a read and a write on the same edge return the old word
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe[l]) begin
                    mem[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/dwb_fwd_merge.sv
module dwb_fwd_merge
    import dwb_pkg::*;
(
    input  rd_req_t           rq_i,
    input  wr_req_t           stg_new_i,
    input  wr_req_t           stg_old_i,
    input  logic [DATA_W-1:0] ram_q_i,
    output logic [DATA_W-1:0] data_o
);

    logic      new_hit;
    logic      old_hit;
    lane_src_e src [LANES];

    assign new_hit = stage_hits(stg_new_i, rq_i);
    assign old_hit = stage_hits(stg_old_i, rq_i);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign src[l] = (new_hit && stg_new_i.be[l]) ? SRC_NEW :
                        (old_hit && stg_old_i.be[l]) ? SRC_OLD : SRC_RAM;

        assign data_o[l*8 +: 8] =
            (src[l] == SRC_NEW) ? stg_new_i.data[l*8 +: 8] :
            (src[l] == SRC_OLD) ? stg_old_i.data[l*8 +: 8] :
                                  ram_q_i[l*8 +: 8];
    end

endmodule

// File: rtl/delayed_write_bypass.sv
module delayed_write_bypass
    import dwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  logic [IDX_W-1:0]  wr_index_i,
    input  logic [WAY_W-1:0]  wr_way_i,
    input  logic [LANES-1:0]  wr_be_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_valid_i,
    input  logic [IDX_W-1:0]  rd_index_i,
    input  logic [WAY_W-1:0]  rd_way_i,
    output logic              rd_vld_o,
    output logic [DATA_W-1:0] rd_data_o
);

    wr_req_t           wr_in;
    wr_req_t           stg_new;
    wr_req_t           stg_old;
    rd_req_t           rq;
    logic [DATA_W-1:0] ram_q;

    assign wr_in = '{vld: wr_valid_i, idx: wr_index_i, way: wr_way_i,
                     be: wr_be_i, data: wr_data_i};

    dwb_wr_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .req_i     (wr_in),
        .stg_new_o (stg_new),
        .stg_old_o (stg_old)
    );

    dwb_data_ram u_ram (
        .clk   (clk),
        .we    (stg_new.vld),
        .waddr (flat_addr(stg_new.idx, stg_new.way)),
        .wbe   (stg_new.be),
        .wdata (stg_new.data),
        .re    (rd_valid_i),
        .raddr (flat_addr(rd_index_i, rd_way_i)),
        .rdata (ram_q)
    );

    // Read lookup register, aligned with the RAM's one-cycle latency
    always_ff @(posedge clk) begin
        if (rst) begin
            rq <= '0;
        end else begin
            rq <= '{vld: rd_valid_i, idx: rd_index_i, way: rd_way_i};
        end
    end

    dwb_fwd_merge u_merge (
        .rq_i      (rq),
        .stg_new_i (stg_new),
        .stg_old_i (stg_old),
        .ram_q_i   (ram_q),
        .data_o    (rd_data_o)
    );

    assign rd_vld_o = rq.vld;

    logic wr_same_word;
    assign wr_same_word = wr_valid_i && rd_valid_i &&
                          (wr_index_i == rd_index_i) && (wr_way_i == rd_way_i);

    // R1
    rst_clears_vld_chk: assert property (@(posedge clk)
        rst |=> !rd_vld_o);

    // R3
    same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_same_word) && $past(&wr_be_i))
        |-> (rd_vld_o && rd_data_o == $past(wr_data_i)));

    // R4
    next_cycle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && $past(rd_valid_i) && !$past(wr_valid_i) &&
         $past(wr_valid_i, 2) && (&$past(wr_be_i, 2)) &&
         ($past(wr_index_i, 2) == $past(rd_index_i)) &&
         ($past(wr_way_i, 2) == $past(rd_way_i)))
        |-> (rd_data_o == $past(wr_data_i, 2)));

    // R2
    ram_path_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_valid_i) && !$past(wr_same_word) &&
         !($past(wr_valid_i, 2) && ($past(wr_index_i, 2) == $past(rd_index_i)) &&
           ($past(wr_way_i, 2) == $past(rd_way_i))))
        |-> (rd_data_o == ram_q));

endmodule

// File: tb/sim_delayed_write_bypass.sv
`timescale 1ns/1ps
module sim_delayed_write_bypass;
    import dwb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid_i;
    logic [IDX_W-1:0]  wr_index_i;
    logic [WAY_W-1:0]  wr_way_i;
    logic [LANES-1:0]  wr_be_i;
    logic [DATA_W-1:0] wr_data_i;
    logic              rd_valid_i;
    logic [IDX_W-1:0]  rd_index_i;
    logic [WAY_W-1:0]  rd_way_i;
    logic              rd_vld_o;
    logic [DATA_W-1:0] rd_data_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] ref_mem [ENTRIES];

    always #10 clk = ~clk;

    delayed_write_bypass u0 (
        .clk(clk), .rst(rst),
        .wr_valid_i(wr_valid_i), .wr_index_i(wr_index_i), .wr_way_i(wr_way_i),
        .wr_be_i(wr_be_i), .wr_data_i(wr_data_i),
        .rd_valid_i(rd_valid_i), .rd_index_i(rd_index_i), .rd_way_i(rd_way_i),
        .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ent(input int idx, input int way);
        return idx * int'(WAYS) + way;
    endfunction

    // One cycle: present inputs at a falling edge, check the read one edge later
    task automatic step(input logic wv, input int widx, input int wway,
                        input logic [LANES-1:0] wbe, input logic [DATA_W-1:0] wd,
                        input logic rv, input int ridx, input int rway,
                        input string tag);
        logic [DATA_W-1:0] exp;
        wr_valid_i = wv;
        wr_index_i = IDX_W'(widx);
        wr_way_i   = WAY_W'(wway);
        wr_be_i    = wbe;
        wr_data_i  = wd;
        rd_valid_i = rv;
        rd_index_i = IDX_W'(ridx);
        rd_way_i   = WAY_W'(rway);
        if (wv) begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (wbe[l]) ref_mem[ent(widx, wway)][l*8 +: 8] = wd[l*8 +: 8];
            end
        end
        exp = ref_mem[ent(ridx, rway)];
        @(posedge clk);
        @(negedge clk);
        wr_valid_i = 1'b0;
        rd_valid_i = 1'b0;
        if (rv) begin
            chk({tag, " vld"}, DATA_W'(rd_vld_o), DATA_W'(1));
            chk({tag, " data"}, rd_data_o, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, 0, 0, 0, "idle");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wr_valid_i = 0; wr_index_i = '0; wr_way_i = '0; wr_be_i = '0; wr_data_i = '0;
        rd_valid_i = 0; rd_index_i = '0; rd_way_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 vld during reset", DATA_W'(rd_vld_o), '0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 vld after reset", DATA_W'(rd_vld_o), '0);
    endtask

    task automatic t_fill();
        for (int e = 0; e < int'(ENTRIES); e++) begin
            step(1, e / int'(WAYS), e % int'(WAYS), '1,
                 {32'(e) * 32'h9E37_79B9, ~32'(e)}, 0, 0, 0, "fill");
        end
        idle(2);
    endtask

    task automatic t_ram_path();
        step(0, 0, 0, '0, '0, 1, 3, 0, "R2 ram read a");
        step(0, 0, 0, '0, '0, 1, 3, 1, "R2 ram read b");
        step(0, 0, 0, '0, '0, 1, 40, 1, "R2 ram read c");
        idle(1);
        chk("R1 vld drops after read", DATA_W'(rd_vld_o), '0);
        // write two cycles ahead of the read must come from the RAM
        step(1, 11, 0, '1, 64'hA5A5_0000_1111_2222, 0, 0, 0, "w");
        step(0, 0, 0, '0, '0, 0, 0, 0, "gap");
        step(0, 0, 0, '0, '0, 1, 11, 0, "R2 write two cycles earlier");
    endtask

    task automatic t_same_cycle();
        step(1, 5, 1, '1, 64'hDEAD_BEEF_0BAD_F00D, 1, 5, 1, "R3 same cycle full");
        step(0, 0, 0, '0, '0, 1, 5, 1, "R4 after same-cycle write");
    endtask

    task automatic t_next_cycle();
        step(1, 12, 0, '1, 64'h0123_4567_89AB_CDEF, 0, 0, 0, "w");
        step(0, 0, 0, '0, '0, 1, 12, 0, "R4 next cycle full");
    endtask

    task automatic t_lanes();
        step(1, 20, 1, 8'hF0, 64'h1122_3344_5566_7788, 1, 20, 1, "R5 partial over RAM");
        step(1, 21, 0, '1, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, 0, "w");
        step(1, 21, 0, 8'h0F, 64'h5555_5555_5555_5555, 1, 21, 0, "R5 new over old lanes");
        step(1, 22, 0, 8'h03, 64'h0000_0000_0000_CCCC, 0, 0, 0, "w");
        step(1, 22, 0, 8'hC0, 64'hDDDD_0000_0000_0000, 1, 22, 0, "R5 new old ram mix");
        step(1, 23, 1, 8'h81, 64'hEE00_0000_0000_00EE, 0, 0, 0, "w");
        step(0, 0, 0, '0, '0, 1, 23, 1, "R5 old stage over RAM");
    endtask

    task automatic t_priority();
        step(1, 30, 0, '1, 64'h1111_1111_1111_1111, 0, 0, 0, "w");
        step(1, 30, 0, '1, 64'h2222_2222_2222_2222, 1, 30, 0, "R6 newer stage wins");
        step(1, 30, 0, 8'h3C, 64'h0000_3333_3333_0000, 1, 30, 0, "R6 newer partial wins");
    endtask

    task automatic t_way_index();
        step(1, 7, 0, '1, 64'hFEED_FACE_CAFE_BABE, 1, 7, 1, "R7 other way same cycle");
        step(0, 0, 0, '0, '0, 1, 7, 1, "R7 other way next cycle");
        step(1, 8, 1, '1, 64'h7777_6666_5555_4444, 1, 9, 1, "R7 other index same cycle");
        step(0, 0, 0, '0, '0, 1, 9, 1, "R7 other index next cycle");
    endtask

    task automatic t_write_after_read();
        step(0, 0, 0, '0, '0, 1, 33, 1, "R8 read before write");
        step(1, 33, 1, '1, 64'h9999_8888_7777_6666, 0, 0, 0, "w");
        step(0, 0, 0, '0, '0, 1, 33, 1, "R8 later read sees write");
    endtask

    task automatic t_disabled();
        step(0, 34, 0, '1, 64'hBAD0_BAD0_BAD0_BAD0, 1, 34, 0, "R9 invalid write same cycle");
        step(0, 34, 0, '1, 64'hBAD1_BAD1_BAD1_BAD1, 1, 34, 0, "R9 invalid write next cycle");
        idle(2);
        step(0, 0, 0, '0, '0, 1, 34, 0, "R9 RAM unchanged");
    endtask

    task automatic t_refill();
        for (int k = 0; k < 8; k++) begin
            step(1, 48 + k, 1, '1, {32'hF00D_0000 + 32'(k), 32'(k) * 32'h0101_0101},
                 (k > 0), 48 + (k > 0 ? k - 1 : 0), 1, "R10 burst trailing read");
        end
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, '0, '0, 1, 48 + k, 1, "R10 burst readback");
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(1, 0) == 1, $urandom_range(3, 0) >> 1, $urandom_range(1, 0),
                 LANES'($urandom), {$urandom, $urandom},
                 $urandom_range(3, 0) != 0, $urandom_range(3, 0) >> 1,
                 $urandom_range(1, 0), "R10 random traffic");
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_ram_path();
        t_same_cycle();
        t_next_cycle();
        t_lanes();
        t_priority();
        t_way_index();
        t_write_after_read();
        t_disabled();
        t_refill();
        t_random();
        idle(2);
        summary();
        $finish;
    end

endmodule